// File: doc/BRIEF.md
# Variable Shift and Rotate Execute Unit

This unit sits in the execute stage of a 64-bit integer pipeline. It takes one 32-bit instruction word and two operand values that have already been read from the register file. It recognises the register-controlled shift class and computes a logical left shift, a logical right shift, an arithmetic right shift or a rotate right. The count comes from the second operand, and the operation runs at 32-bit or 64-bit width.

The result is held in one register stage. A word presented in one cycle produces its match flag, destination index and result after the next rising clock edge. Register-file access, writeback and condition flags belong to neighbouring blocks.

Top module: `shv_unit`

## Requirements
- R1: The word is accepted (`hit` = 1) only when bits 30..21 equal 0011010110 and bits 15..12 equal 0010. Every other word gives `hit` = 0.
- R2: Bit 31 of the word sets the operating width: 1 means 64-bit and 0 means 32-bit.
- R3: On a hit, `dst_idx` carries bits 4..0 of the word.
- R4: The effective count is `opnd_b` modulo the width: bits 5..0 in 64-bit mode and bits 4..0 in 32-bit mode. Higher bits of `opnd_b` have no effect.
- R5: Bits 11..10 = 00 give a logical left shift. Vacated low bits are filled with zeros.
- R6: Bits 11..10 = 01 give a logical right shift. Vacated high bits are filled with zeros.
- R7: Bits 11..10 = 10 give an arithmetic right shift. Vacated bits take the sign bit, which is bit 63 in 64-bit mode and bit 31 in 32-bit mode.
- R8: Bits 11..10 = 11 give a rotate right: result bit k equals operand bit (k+n) mod width. An effective count of zero returns the operand unchanged.
- R9: In 32-bit mode, bits 63..32 of `opnd_a` have no effect and bits 63..32 of `result` are zero.
- R10: When `hit` is 0, `result` and `dst_idx` are zero.
- R11: Outputs appear one clock edge after the inputs. While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| insn | input | 32 | Instruction word to decode |
| opnd_a | input | 64 | Value to be shifted or rotated |
| opnd_b | input | 64 | Value supplying the count |
| hit | output | 1 | Word belongs to the shift class (registered) |
| dst_idx | output | 5 | Destination register index (registered) |
| result | output | 64 | Shifted or rotated value (registered) |

## Verification
The unit holds no state beyond the output register. A wrong value in it shows up on `result`, `hit` or `dst_idx` at the next sampling point and is cleared by the next word. Any fault in decode, count masking or shift selection is therefore seen one cycle after the word that exposes it. For that reason the stimulus drives counts of 0, 1, width−1, exactly the width and above it, sign-set operands, and near-miss words in both widths. Random words and operands are compared against a bit-by-bit model on every cycle.

// File: rtl/shv_pkg.sv
package shv_pkg;

    localparam int RIDX_W = 5;

    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_ROR = 2'b11
    } shkind_e;

    typedef struct packed {
        logic              hit;
        logic              wide;
        shkind_e           kind;
        logic [RIDX_W-1:0] dst;
    } dec_t;

endpackage

// File: rtl/shv_decode.sv
module shv_decode
    import shv_pkg::*;
#(
    parameter int IW = 32
) (
    input  logic [IW-1:0] insn,
    output dec_t          dec
);
    localparam int          CLS_HI  = 30;
    localparam int          CLS_LO  = 21;
    localparam logic [9:0]  CLS_VAL = 10'b0011010110;
    localparam int          SUB_HI  = 15;
    localparam int          SUB_LO  = 12;
    localparam logic [3:0]  SUB_VAL = 4'b0010;
    localparam int          WID_BIT = 31;
    localparam int          KND_LO  = 10;

    logic unused_fields;
    assign unused_fields = ^{insn[20:16], insn[9:5]};

    always_comb begin
        dec.hit  = (insn[CLS_HI:CLS_LO] == CLS_VAL) && (insn[SUB_HI:SUB_LO] == SUB_VAL);
        dec.wide = insn[WID_BIT];
        dec.kind = shkind_e'(insn[KND_LO+1:KND_LO]);
        dec.dst  = insn[RIDX_W-1:0];
    end
endmodule

// File: rtl/shv_count.sv
module shv_count #(
    parameter int XLEN = 64,
    localparam int CW  = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] opnd_b,
    input  logic            wide,
    output logic [CW-1:0]   cnt
);
    logic unused_hi;
    assign unused_hi = ^opnd_b[XLEN-1:CW];

    always_comb begin
        if (wide) cnt = opnd_b[CW-1:0];
        else      cnt = {1'b0, opnd_b[CW-2:0]};
    end
endmodule

// File: rtl/shv_core.sv
module shv_core
    import shv_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int HLEN = XLEN / 2,
    localparam int CW   = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] opnd_a,
    input  logic [CW-1:0]   cnt,
    input  logic            wide,
    input  shkind_e         kind,
    output logic [XLEN-1:0] res
);
    logic [XLEN-1:0]   lsl_w, lsr_w, asr_w, ror_w;
    logic [2*XLEN-1:0] dbl_w;
    logic [HLEN-1:0]   a_n, lsl_n, lsr_n, asr_n, ror_n;
    logic [XLEN-1:0]   dbl_n;
    logic [CW-2:0]     cnt_n;

    always_comb begin
        dbl_w = {opnd_a, opnd_a} >> cnt;
        lsl_w = opnd_a << cnt;
        lsr_w = opnd_a >> cnt;
        asr_w = $signed(opnd_a) >>> cnt;
        ror_w = dbl_w[XLEN-1:0];

        a_n   = opnd_a[HLEN-1:0];
        cnt_n = cnt[CW-2:0];
        dbl_n = {a_n, a_n} >> cnt_n;
        lsl_n = a_n << cnt_n;
        lsr_n = a_n >> cnt_n;
        asr_n = $signed(a_n) >>> cnt_n;
        ror_n = dbl_n[HLEN-1:0];

        unique case (kind)
            SK_LSL:  res = wide ? lsl_w : {{HLEN{1'b0}}, lsl_n};
            SK_LSR:  res = wide ? lsr_w : {{HLEN{1'b0}}, lsr_n};
            SK_ASR:  res = wide ? asr_w : {{HLEN{1'b0}}, asr_n};
            default: res = wide ? ror_w : {{HLEN{1'b0}}, ror_n};
        endcase
    end
endmodule

// File: rtl/shv_unit.sv
module shv_unit
    import shv_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int IW   = 32,
    localparam int CW  = $clog2(XLEN),
    localparam int HLEN = XLEN / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IW-1:0]     insn,
    input  logic [XLEN-1:0]   opnd_a,
    input  logic [XLEN-1:0]   opnd_b,
    output logic              hit,
    output logic [RIDX_W-1:0] dst_idx,
    output logic [XLEN-1:0]   result
);
    typedef struct packed {
        logic              hit;
        logic              wide;
        logic [RIDX_W-1:0] dst;
        logic [XLEN-1:0]   res;
    } stage_t;

    dec_t            dec;
    logic [CW-1:0]   cnt;
    logic [XLEN-1:0] core_res;
    stage_t          stage_d, stage_q;

    shv_decode #(.IW(IW)) i_decode (
        .insn (insn),
        .dec  (dec)
    );

    shv_count #(.XLEN(XLEN)) i_count (
        .opnd_b (opnd_b),
        .wide   (dec.wide),
        .cnt    (cnt)
    );

    shv_core #(.XLEN(XLEN)) i_core (
        .opnd_a (opnd_a),
        .cnt    (cnt),
        .wide   (dec.wide),
        .kind   (dec.kind),
        .res    (core_res)
    );

    always_comb begin
        stage_d = '0;
        if (dec.hit) begin
            stage_d.hit  = 1'b1;
            stage_d.wide = dec.wide;
            stage_d.dst  = dec.dst;
            stage_d.res  = core_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign hit     = stage_q.hit;
    assign dst_idx = stage_q.dst;
    assign result  = stage_q.res;

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (result == '0 && dst_idx == '0)); // R10
    AST_CLASS_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ($past(insn[15:12]) == 4'b0010)); // R1
    AST_DST_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (dst_idx == $past(insn[RIDX_W-1:0]))); // R3
    AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !stage_q.wide) |-> (result[XLEN-1:HLEN] == '0)); // R9
    AST_ROR_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && stage_q.wide && $past(insn[11:10]) == 2'b11 && $past(opnd_b[CW-1:0]) == '0)
        |-> (result == $past(opnd_a))); // R8
endmodule

// File: tb/test_shv_unit.sv
module test_shv_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] CLS = 10'b0011010110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn = '0;
    logic [63:0] opnd_a = '0, opnd_b = '0;
    logic        hit;
    logic [4:0]  dst_idx;
    logic [63:0] result;

    int    n_vec = 0, n_bad = 0;
    logic  pend = 1'b0;
    logic  e_hit;
    logic [4:0]  e_dst;
    logic [63:0] e_res;
    string e_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    shv_unit i_shv_unit (
        .clk(clk), .rst_n(rst_n), .insn(insn), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .hit(hit), .dst_idx(dst_idx), .result(result)
    );

    function automatic logic [31:0] mk(logic sf, logic [1:0] op, logic [4:0] rm,
                                       logic [4:0] rn, logic [4:0] rd);
        return {sf, CLS, rm, 4'b0010, op, rn, rd};
    endfunction

    function automatic logic [63:0] model(logic [31:0] i, logic [63:0] a, logic [63:0] b);
        int w = i[31] ? 64 : 32;
        int n = int'(b % 64'(w));
        logic [63:0] r = '0;
        for (int k = 0; k < w; k++) begin
            case (i[11:10])
                2'd0: r[k] = (k >= n) ? a[k-n] : 1'b0;
                2'd1: r[k] = (k + n < w) ? a[k+n] : 1'b0;
                2'd2: r[k] = (k + n < w) ? a[k+n] : a[w-1];
                default: r[k] = a[(k + n) % w];
            endcase
        end
        return r;
    endfunction

    task automatic compare();
        n_vec++;
        if (hit !== e_hit || dst_idx !== e_dst || result !== e_res) begin
            n_bad++;
            $display("FAIL %s: got hit=%0b dst=%0d res=%h expected hit=%0b dst=%0d res=%h",
                     e_tag, hit, dst_idx, result, e_hit, e_dst, e_res);
        end
    endtask

    task automatic step(input logic [31:0] i, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        if (pend) compare();
        insn = i; opnd_a = a; opnd_b = b;
        e_hit = (i[30:21] == CLS) && (i[15:12] == 4'b0010);
        if (e_hit) begin
            e_dst = i[4:0];
            e_res = model(i, a, b);
            case (i[11:10])
                2'd0: e_tag = "R5 LSL R3";
                2'd1: e_tag = "R6 LSR R3";
                2'd2: e_tag = "R7 ASR R3";
                default: e_tag = "R8 ROR R3";
            endcase
            e_tag = {e_tag, i[31] ? " R2 R4 wide" : " R2 R4 R9 narrow"};
        end else begin
            e_dst = '0; e_res = '0; e_tag = "R1 R10 miss";
        end
        pend = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] pats[4];
        logic [63:0] cnts[7];
        pats[0] = 64'h8123_4567_89AB_CDEF; pats[1] = 64'h0000_0000_8000_0001;
        pats[2] = 64'h7FFF_FFFF_FFFF_FFFF; pats[3] = 64'hDEAD_BEEF_7654_3210;
        // R11: reset clears outputs
        opnd_a = '1; opnd_b = '1; insn = mk(1, 2'b10, 5'd1, 5'd2, 5'd31);
        repeat (3) @(negedge clk);
        e_hit = 0; e_dst = '0; e_res = '0; e_tag = "R11 reset";
        compare();
        rst_n = 1'b1;
        // R4 counts: 0, 1, 31, 32, 63, 64, large
        for (int s = 0; s < 2; s++) begin
            cnts[0] = 0; cnts[1] = 1; cnts[2] = s ? 63 : 31; cnts[3] = s ? 64 : 32;
            cnts[4] = s ? 65 : 33; cnts[5] = 64'hFFFF_FFFF_FFFF_FFC0; cnts[6] = 64'h1234_5678_0000_0025;
            for (int op = 0; op < 4; op++)
                for (int p = 0; p < 4; p++)
                    for (int c = 0; c < 7; c++)
                        step(mk(s[0], op[1:0], 5'(c), 5'(p), 5'(op*7+c)), pats[p], cnts[c]);
        end
        // R1 R10: near-miss words
        step(mk(1, 2'b11, 5'd3, 5'd4, 5'd5) ^ 32'h0020_0000, pats[0], 64'd4);
        step(mk(1, 2'b00, 5'd3, 5'd4, 5'd5) ^ 32'h4000_0000, pats[1], 64'd4);
        step(mk(0, 2'b01, 5'd3, 5'd4, 5'd5) ^ 32'h0000_1000, pats[2], 64'd4);
        step(mk(0, 2'b10, 5'd3, 5'd4, 5'd5) ^ 32'h0000_8000, pats[3], 64'd4);
        step(32'h0, pats[0], 64'd1);
        // random mix
        for (int r = 0; r < 3000; r++) begin
            logic [31:0] w = mk($urandom_range(0, 1) == 1, 2'($urandom), 5'($urandom),
                                5'($urandom), 5'($urandom));
            if ($urandom_range(0, 7) == 0) w ^= 32'(1) << $urandom_range(10, 30);
            step(w, {$urandom, $urandom}, {$urandom, $urandom});
        end
        @(negedge clk);
        compare();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule